// File: doc/BRIEF.md
# SDRAM Write Command Sequencer with Per-Bank Open-Row Tracking

This block takes write requests from a single master and turns them into SDRAM commands. Each request carries a flat word address, a data word and a transfer-type flag. The flag marks the request as a sequential beat of a burst; when it is low, the request is a single write. The flat address is split into a column field (the least significant bits), then a bank field, then a row field. A page is one full sweep of the column field.

For every bank the sequencer keeps a record of which row is open. A write to the open row goes out as a WRITE command on the next cycle. Two cases instead produce a PRECHARGE of that bank, then an ACTIVATE of the new row, then the WRITE:

- the write targets a different row of an open bank;
- a sequential beat wraps into a new page.

A write to a bank with no open row needs only the ACTIVATE and the WRITE. The sequencer inserts the precharge-to-activate gap (T_RP) and the activate-to-write gap (T_RCD) as NOP cycles. While it does so, it holds the master off with a low ready signal.

Top module: `sdram_wr_seq`

## Requirements
- R1: A request whose bank has an open row equal to the request's row, and which is not a page wrap, is issued as one WRITE command in the cycle after acceptance, with no PRECHARGE or ACTIVATE and with req_ready staying high.
- R2: After reset every bank record is empty, so the first write to a bank issues ACTIVATE then WRITE, with no PRECHARGE.
- R3: A write to an open bank whose open row differs from the request's row issues PRECHARGE of that bank, then ACTIVATE of the new row, then WRITE.
- R4: An ACTIVATE follows its PRECHARGE by exactly T_RP cycles, and a WRITE follows its ACTIVATE by exactly T_RCD cycles, with NOP driven on every cycle in between.
- R5: req_ready is low from the cycle a PRECHARGE or ACTIVATE appears until the cycle its WRITE appears. Each accepted miss therefore stalls the next request by T_RP+T_RCD cycles when a PRECHARGE was needed, and by T_RCD cycles otherwise.
- R6: A sequential beat (req_seq=1) whose column field is zero is a page wrap. It forces PRECHARGE, ACTIVATE and WRITE even when the record matches the row. A single write (req_seq=0) to column zero of the open row is an ordinary hit.
- R7: A PRECHARGE clears only the record of its own bank. Open rows in other banks stay valid and keep producing hits.
- R8: Commands are driven on sd_cmd as {RAS_n, CAS_n, WE_n}: NOP=111, ACTIVATE=011, WRITE=100, PRECHARGE=010.
  - PRECHARGE drives sd_addr[10]=0 and the target bank on sd_ba.
  - ACTIVATE drives the row on sd_addr.
  - WRITE drives the zero-extended column on sd_addr and the request data on sd_dq in the same cycle.
- R9: The address is split as column = req_addr[COL_W-1:0], bank = the next BANK_W bits, and row = the top ROW_W bits.
- R10: In reset, sd_cmd is NOP and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_seq | input | 1 | 1 = sequential burst beat, 0 = single write |
| req_addr | input | COL_W+BANK_W+ROW_W | Flat word address |
| req_data | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted on a clock edge where req_valid and req_ready are both high |
| sd_cmd | output | 3 | {RAS_n, CAS_n, WE_n} command |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Row or column address; bit 10 is the precharge-all select |
| sd_dq | output | DATA_W | Write data, valid with WRITE |

## Verification
The bench drives each of the following cases:

- **First touch of a bank.** A design that wrongly precharged a bank with no open row shows up as an extra command on the bus.
- **Row change in an open bank.** A design that reused a stale row would write without the PRECHARGE/ACTIVATE pair.
- **Sequential wrap into a new page, next to a single write to column zero of the same row.** A design that ignored the transfer-type flag would either miss the forced reopen or reopen needlessly.
- **A hit in a second bank right after a precharge.** This catches a precharge that clears the wrong record or all records.

For every command the bench compares the cycle gap from the previous command against T_RP and T_RCD, and it counts the ready stall of each request. Off-by-one timers and early release of the master therefore show up as wrong gaps or wrong stall counts.

// File: rtl/sdram_seq_pkg.sv
// Shared command encoding and sequencer state for the SDRAM write sequencer.
package sdram_seq_pkg;
    // {RAS_n, CAS_n, WE_n}
    typedef enum logic [2:0] {
        CMD_PRE = 3'b010,
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_NOP = 3'b111
    } sd_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RP,
        ST_RCD
    } seq_st_e;
endpackage

// File: rtl/sdram_addr_split.sv
// Splits a flat word address into column, bank and row fields (column at the
// least significant end) and flags a sequential beat that wraps into a new page.
// Assumes the page boundary is where the column field returns to zero.
module sdram_addr_split #(
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    localparam int ADDR_W = COL_W + BANK_W + ROW_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              seq,
    output logic [COL_W-1:0]  col,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic              wrap
);
    // Field extraction and page-wrap detection
    always_comb begin
        col  = addr[COL_W-1:0];
        bank = addr[COL_W +: BANK_W];
        row  = addr[COL_W+BANK_W +: ROW_W];
        wrap = seq && (col == '0);
    end
endmodule

// File: rtl/sdram_row_table.sv
// Keeps one open-row record (valid bit and row) per bank. ACTIVATE sets the
// record of its bank; PRECHARGE clears only that bank's record.
// Assumes set and clear are never requested in the same cycle.
module sdram_row_table #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    localparam int NB    = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] look_bank,
    output logic              look_valid,
    output logic [ROW_W-1:0]  look_row,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row
);
    logic [NB-1:0]    rec_valid;
    logic [ROW_W-1:0] rec_row [NB];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        // One bank's record update
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rec_valid[b] <= 1'b0;
                rec_row[b]   <= '0;
            end else if (set_en && upd_bank == BANK_W'(b)) begin
                rec_valid[b] <= 1'b1;
                rec_row[b]   <= upd_row;
            end else if (clr_en && upd_bank == BANK_W'(b)) begin
                rec_valid[b] <= 1'b0;
            end
        end
    end

    // Lookup of the requested bank's record
    always_comb begin
        look_valid = rec_valid[look_bank];
        look_row   = rec_row[look_bank];
    end
endmodule

// File: rtl/sdram_gap_timer.sv
// Down-counter for the inter-command gap. Loaded with (gap-1) on the edge a
// command issues; reports done once it reaches zero.
module sdram_gap_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    // Load or count down toward zero
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Gap elapsed
    always_comb done = (cnt == '0);
endmodule

// File: rtl/sdram_wr_seq.sv
// Write command sequencer: turns single or burst write requests into SDRAM
// PRECHARGE / ACTIVATE / WRITE commands, reusing the open row of each bank.
// Assumes ROW_W > 10, COL_W <= 10, T_RP >= 1 and T_RCD >= 1; reads, refresh
// and initialisation are handled elsewhere.
module sdram_wr_seq #(
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int DATA_W = 16,
    parameter int T_RP   = 2,
    parameter int T_RCD  = 2,
    localparam int ADDR_W = COL_W + BANK_W + ROW_W,
    localparam int T_MAX  = (T_RP > T_RCD) ? T_RP : T_RCD,
    localparam int CNT_W  = $clog2(T_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_seq,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    output logic [2:0]        sd_cmd,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [DATA_W-1:0] sd_dq
);
    import sdram_seq_pkg::*;

    logic [COL_W-1:0]  in_col;
    logic [BANK_W-1:0] in_bank;
    logic [ROW_W-1:0]  in_row;
    logic              in_wrap;

    logic              rec_valid;
    logic [ROW_W-1:0]  rec_row;
    logic              tbl_set, tbl_clr;
    logic [BANK_W-1:0] upd_bank;
    logic [ROW_W-1:0]  upd_row;

    logic              tmr_load, tmr_done;
    logic [CNT_W-1:0]  tmr_val;

    seq_st_e           st, st_n;
    logic [COL_W-1:0]  cap_col;
    logic [BANK_W-1:0] cap_bank;
    logic [ROW_W-1:0]  cap_row;
    logic [DATA_W-1:0] cap_data;
    logic              cap_en;

    sd_cmd_e           cmd_n;
    logic [BANK_W-1:0] ba_n;
    logic [ROW_W-1:0]  a_n;
    logic              dq_en;
    logic [DATA_W-1:0] dq_n;
    logic              accept, hit;

    sdram_addr_split #(.COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_split (
        .addr(req_addr), .seq(req_seq),
        .col(in_col), .bank(in_bank), .row(in_row), .wrap(in_wrap)
    );

    sdram_row_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_n),
        .look_bank(in_bank), .look_valid(rec_valid), .look_row(rec_row),
        .set_en(tbl_set), .clr_en(tbl_clr), .upd_bank(upd_bank), .upd_row(upd_row)
    );

    sdram_gap_timer #(.CNT_W(CNT_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    // Master handshake: requests are taken only while idle
    always_comb begin
        req_ready = (st == ST_IDLE);
        accept    = req_valid && req_ready;
        hit       = rec_valid && (rec_row == in_row) && !in_wrap;
    end

    // Record update source: live request while idle, captured request otherwise
    always_comb begin
        upd_bank = (st == ST_IDLE) ? in_bank : cap_bank;
        upd_row  = (st == ST_IDLE) ? in_row  : cap_row;
    end

    // Next command, next state and side effects
    always_comb begin
        st_n     = st;
        cmd_n    = CMD_NOP;
        ba_n     = sd_ba;
        a_n      = sd_addr;
        dq_en    = 1'b0;
        dq_n     = cap_data;
        tbl_set  = 1'b0;
        tbl_clr  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_en   = 1'b0;
        unique case (st)
            ST_IDLE: if (accept) begin
                ba_n   = in_bank;
                cap_en = 1'b1;
                if (hit) begin
                    cmd_n = CMD_WR;
                    a_n   = ROW_W'(in_col);
                    dq_en = 1'b1;
                    dq_n  = req_data;
                end else if (rec_valid) begin
                    cmd_n    = CMD_PRE;
                    a_n      = '0;
                    tbl_clr  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_RP - 1);
                    st_n     = ST_RP;
                end else begin
                    cmd_n    = CMD_ACT;
                    a_n      = in_row;
                    tbl_set  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_RCD - 1);
                    st_n     = ST_RCD;
                end
            end
            ST_RP: if (tmr_done) begin
                cmd_n    = CMD_ACT;
                ba_n     = cap_bank;
                a_n      = cap_row;
                tbl_set  = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_RCD - 1);
                st_n     = ST_RCD;
            end
            ST_RCD: if (tmr_done) begin
                cmd_n = CMD_WR;
                ba_n  = cap_bank;
                a_n   = ROW_W'(cap_col);
                dq_en = 1'b1;
                dq_n  = cap_data;
                st_n  = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // State and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cap_col  <= '0;
            cap_bank <= '0;
            cap_row  <= '0;
            cap_data <= '0;
        end else begin
            st <= st_n;
            if (cap_en) begin
                cap_col  <= in_col;
                cap_bank <= in_bank;
                cap_row  <= in_row;
                cap_data <= req_data;
            end
        end
    end

    // Registered command bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_cmd  <= CMD_NOP;
            sd_ba   <= '0;
            sd_addr <= '0;
            sd_dq   <= '0;
        end else begin
            sd_cmd  <= cmd_n;
            sd_ba   <= ba_n;
            sd_addr <= a_n;
            if (dq_en) sd_dq <= dq_n;
        end
    end
endmodule

// File: rtl/sdram_wr_seq_chk.sv
// Protocol checker for sdram_wr_seq: models bank open/closed state from the
// command bus and checks ordering, gaps and precharge addressing.
module sdram_wr_seq_chk #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int T_RP   = 2,
    parameter int T_RCD  = 2,
    localparam int NB    = 1 << BANK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [2:0]        sd_cmd,
    input logic [BANK_W-1:0] sd_ba,
    input logic [ROW_W-1:0]  sd_addr
);
    localparam logic [2:0] C_PRE = 3'b010, C_ACT = 3'b011, C_WR = 3'b100;

    logic [NB-1:0] bank_open;
    logic [7:0]    since_pre, since_act;
    logic          pre_pend, act_pend;

    // Bank state and gap counters observed on the command bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_open <= '0;
            since_pre <= '0;
            since_act <= '0;
            pre_pend  <= 1'b0;
            act_pend  <= 1'b0;
        end else begin
            if (since_pre != 8'hFF) since_pre <= since_pre + 1'b1;
            if (since_act != 8'hFF) since_act <= since_act + 1'b1;
            if (sd_cmd == C_PRE) begin
                bank_open[sd_ba] <= 1'b0;
                since_pre <= 8'd1;
                pre_pend  <= 1'b1;
            end
            if (sd_cmd == C_ACT) begin
                bank_open[sd_ba] <= 1'b1;
                since_act <= 8'd1;
                pre_pend  <= 1'b0;
                act_pend  <= 1'b1;
            end
            if (sd_cmd == C_WR) act_pend <= 1'b0;
        end
    end

    // R8
    pre_a10_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cmd == C_PRE |-> sd_addr[10] == 1'b0);
    // R2
    act_closed_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cmd == C_ACT |-> !bank_open[sd_ba]);
    // R3
    pre_open_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cmd == C_PRE |-> bank_open[sd_ba]);
    // R1
    wr_open_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cmd == C_WR |-> bank_open[sd_ba]);
    // R4
    rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == C_ACT && pre_pend) |-> since_pre >= 8'(T_RP));
    // R4
    rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == C_WR && act_pend) |-> since_act >= 8'(T_RCD));
    // R5
    stall_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> (sd_cmd == C_PRE || sd_cmd == C_ACT));
    // R5
    stall_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> sd_cmd == C_WR);
endmodule

bind sdram_wr_seq sdram_wr_seq_chk #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .T_RP(T_RP), .T_RCD(T_RCD)
) i_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
    .sd_cmd(sd_cmd), .sd_ba(sd_ba), .sd_addr(sd_addr)
);

// File: tb/test_sdram_wr_seq.sv
// Scoreboard bench: the driver predicts commands into a queue, the monitor
// compares each non-NOP command and its cycle gap as the design emits it.
module test_sdram_wr_seq;
    localparam int COL_W = 8, BANK_W = 2, ROW_W = 12, DATA_W = 16;
    localparam int T_RP = 3, T_RCD = 2;
    localparam int ADDR_W = COL_W + BANK_W + ROW_W;
    localparam int NB = 1 << BANK_W;
    localparam logic [2:0] C_NOP = 3'b111, C_PRE = 3'b010, C_ACT = 3'b011, C_WR = 3'b100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_seq = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic              req_ready;
    logic [2:0]        sd_cmd;
    logic [BANK_W-1:0] sd_ba;
    logic [ROW_W-1:0]  sd_addr;
    logic [DATA_W-1:0] sd_dq;

    sdram_wr_seq #(.COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .DATA_W(DATA_W),
                   .T_RP(T_RP), .T_RCD(T_RCD)) i_sdram_wr_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seq(req_seq),
        .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready),
        .sd_cmd(sd_cmd), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq(sd_dq)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [2:0]        cmd;
        logic [BANK_W-1:0] ba;
        logic [ROW_W-1:0]  a;
        logic [DATA_W-1:0] d;
        int                gap;
        string             tag;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0, failures = 0;
    int         cyc = 0, last_cmd_cyc = 0;
    logic       m_open [NB];
    logic [ROW_W-1:0] m_row [NB];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare every issued command with the prediction
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (sd_cmd != C_NOP) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R1", "unexpected cmd", sd_cmd, C_NOP);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(sd_cmd == e.cmd, e.tag, "cmd", sd_cmd, e.cmd);
                    check(sd_ba == e.ba, "R8", "bank", sd_ba, e.ba);
                    check(sd_addr == e.a, "R8", "addr", sd_addr, e.a);
                    if (e.cmd == C_WR)
                        check(sd_dq == e.d, "R8", "data", sd_dq, e.d);
                    if (e.gap >= 0)
                        check(cyc - last_cmd_cyc == e.gap, "R4", "gap",
                              cyc - last_cmd_cyc, e.gap);
                end
                last_cmd_cyc = cyc;
            end
        end
    end

    function automatic void push(input logic [2:0] c, input logic [BANK_W-1:0] b,
                                 input logic [ROW_W-1:0] a, input logic [DATA_W-1:0] d,
                                 input int gap, input string tag);
        exp_t e;
        e.cmd = c; e.ba = b; e.a = a; e.d = d; e.gap = gap; e.tag = tag;
        sb.push_back(e);
    endfunction

    // Driver: predict commands, issue one request, measure the stall after it
    task automatic send(input logic [ROW_W-1:0] row, input logic [BANK_W-1:0] bank,
                        input logic [COL_W-1:0] col, input bit seq,
                        input logic [DATA_W-1:0] data, input string tag);
        int exp_stall, stall;
        bit wrap;
        wrap = seq && (col == '0);
        if (m_open[bank] && m_row[bank] == row && !wrap) begin
            push(C_WR, bank, ROW_W'(col), data, -1, tag);
            exp_stall = 0;
        end else if (m_open[bank]) begin
            push(C_PRE, bank, '0, '0, -1, tag);
            push(C_ACT, bank, row, '0, T_RP, tag);
            push(C_WR, bank, ROW_W'(col), data, T_RCD, tag);
            exp_stall = T_RP + T_RCD;
        end else begin
            push(C_ACT, bank, row, '0, -1, tag);
            push(C_WR, bank, ROW_W'(col), data, T_RCD, tag);
            exp_stall = T_RCD;
        end
        m_open[bank] = 1'b1;
        m_row[bank]  = row;
        @(negedge clk);
        req_valid = 1'b1;
        req_seq   = seq;
        req_addr  = {row, bank, col};
        req_data  = data;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        stall = 0;
        while (!req_ready && stall < 100) begin
            stall++;
            @(negedge clk);
        end
        check(stall == exp_stall, "R5", "stall", stall, exp_stall);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            m_open[b] = 1'b0;
            m_row[b]  = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check(sd_cmd == C_NOP, "R10", "cmd in reset", sd_cmd, C_NOP);
        check(req_ready == 1'b1, "R10", "ready in reset", req_ready, 1);
        rst_n = 1'b1;

        send(12'h005, 2'd0, 8'h03, 1'b0, 16'hA001, "R2");   // R2 first access
        send(12'h005, 2'd0, 8'h04, 1'b1, 16'hA002, "R1");   // R1 hit, sequential
        send(12'h007, 2'd1, 8'h01, 1'b0, 16'hA003, "R2");   // R2 another bank
        send(12'h009, 2'd0, 8'h02, 1'b0, 16'hA004, "R3");   // R3 row miss
        send(12'h007, 2'd1, 8'h09, 1'b0, 16'hA005, "R7");   // R7 other bank kept
        send(12'h009, 2'd0, 8'h00, 1'b1, 16'hA006, "R6");   // R6 page wrap
        send(12'h009, 2'd0, 8'h00, 1'b0, 16'hA007, "R6");   // R6 single to col 0
        send(12'h009, 2'd0, 8'h05, 1'b1, 16'hA008, "R1");   // R1 burst beat
        send(12'hFFF, 2'd3, 8'hFF, 1'b0, 16'hA009, "R9");   // R9 top fields
        send(12'h800, 2'd3, 8'h80, 1'b0, 16'hA00A, "R3");   // R3 miss in bank 3
        send(12'h007, 2'd1, 8'h0A, 1'b1, 16'hA00B, "R7");   // R7 still open
        send(12'h123, 2'd2, 8'h40, 1'b1, 16'hA00C, "R2");   // R2 seq first access

        repeat (10) @(negedge clk);
        check(sb.size() == 0, "R1", "pending predictions", sb.size(), 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule